// File: doc/BRIEF.md
# Charge and Discharge Rate Flag Generator

This block condenses the activity of a battery monitor into one read-only status byte. One input carries single-cycle pulses, each for a unit of charge counted. A second input carries a digitized sense voltage in millivolts, together with a strobe that marks each new sample. From these the block keeps three things: a fast-charge flag, a five-level discharge regime code and an overload flag.

The fast-charge flag goes high as soon as a charge action begins. It stays high while every measurement window, one second long and set by a clock-count parameter, holds at least two charge pulses. It drops after the first complete window that holds fewer. The discharge code and the overload flag follow the most recent strobed voltage sample. Software reads the byte through a small address/data read port.

Top module: `rate_flag_gen`

## Requirements
- R1: The status byte reads on `rd_data` whenever `rd_addr` equals 06h. Bit 7 is the fast-charge flag, bits 6:4 the discharge code, bits 3:1 are always zero and bit 0 is the overload flag. Any other address reads 00h.
- R2: While `rst_n` is low, every flag and the code read zero. After `rst_n` rises, the internal state leaves reset on the second rising clock edge, and the measurement window starts at count zero.
- R3: A high `chg_start` sampled at a clock edge sets the fast-charge flag at that edge. It also restarts the window, and the window's pulse tally becomes 1 if `chg_pulse` is high in that same cycle, otherwise 0.
- R4: A window is `WIN_CYCLES` clock cycles long. At its last cycle the window closes, and the fast-charge flag is held if that window collected 2 or more pulses.
- R5: At the close of a window that collected fewer than 2 pulses, the fast-charge flag clears at that edge, unless `chg_start` is high in that cycle.
- R6: On a strobed sample the code becomes 000 for mv < 50, 001 for 50 ≤ mv < 100, 010 for 100 ≤ mv < 150, 011 for 150 ≤ mv < 253, and 100 for mv ≥ 253. Each boundary value belongs to the higher regime.
- R7: On a strobed sample the overload flag becomes 1 when mv ≥ 50 and 0 when mv < 50.
- R8: While `sample_stb` is low, the code and the overload flag hold their values whatever `sense_mv` does.
- R9: When `chg_start` coincides with the last cycle of a window, the start wins. The flag is set, and a new window begins from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chg_start | input | 1 | One-cycle marker that a charge action begins |
| chg_pulse | input | 1 | One-cycle pulse per counted charge unit |
| sense_mv | input | MV_W | Sense voltage sample in millivolts |
| sample_stb | input | 1 | Marks `sense_mv` as a new sample |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, status byte at address 06h |

## Verification
On every cycle, the assertions check four things. A charge start sets the flag one edge later. The flag never rises without a start. A busy window never disturbs the flag. The code and the overload flag stay frozen between strobes and agree with each other. Only the bench's scenarios can show three further behaviours: the flag clears at exactly the right window edge after a sparse window, the start-versus-window-end collision, and the exact boundary values 49/50, 99/100, 149/150 and 252/253. The bench covers these with directed cases and with a random mix of charge phases, pulse densities, voltages and read addresses, compared every cycle against a bench reference model.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  localparam int unsigned NUM_THR = 4;
  localparam int unsigned CODE_W  = 3;
  // Regime boundaries in millivolts, ascending; each value opens the higher regime
  localparam int unsigned DCH_THR [NUM_THR] = '{50, 100, 150, 253};
  localparam logic [7:0]  STATUS_ADDR = 8'h06;

  typedef struct packed {
    logic              fast_chg;
    logic [CODE_W-1:0] dch_code;
    logic [2:0]        rsv;
    logic              ovld;
  } status_t;
endpackage

// File: rtl/charge_rate_mon.sv
module charge_rate_mon #(
  parameter int unsigned WIN_CYCLES = 1000,
  parameter int unsigned MIN_PULSES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_start,
  input  logic chg_pulse,
  output logic fast_chg
);
  localparam int unsigned WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int unsigned CNT_W = $clog2(MIN_PULSES + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_PULSES);

  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_sum;
  logic             cr_q, cr_d;
  logic             win_end;

  assign win_end = (win_q == WIN_LAST);

  always_comb begin
    if (chg_pulse && (cnt_q != CNT_SAT)) cnt_sum = cnt_q + CNT_W'(1);
    else                                 cnt_sum = cnt_q;
  end

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    cr_d  = cr_q;
    if (chg_start) begin
      cr_d  = 1'b1;
      win_d = '0;
      cnt_d = chg_pulse ? CNT_W'(1) : '0;
    end else if (win_end) begin
      if (cnt_sum < CNT_SAT) cr_d = 1'b0;
      win_d = '0;
      cnt_d = '0;
    end else begin
      win_d = win_q + WIN_W'(1);
      cnt_d = cnt_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      cr_q  <= 1'b0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      cr_q  <= cr_d;
    end
  end

  assign fast_chg = cr_q;

  // R3: a start sets the flag at the next edge
  p_start_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chg_start |=> cr_q);
  // R3: the flag only ever rises because of a start
  p_rise_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_q) |-> $past(chg_start));
  // R4: a window that closes with enough pulses leaves the flag untouched
  p_busy_window_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !chg_start && (cnt_sum == CNT_SAT)) |=> $stable(cr_q));
  // R4: window position never passes its last cycle
  p_window_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WIN_LAST);
endmodule

// File: rtl/discharge_classifier.sv
module discharge_classifier
  import rfg_pkg::*;
#(
  parameter int unsigned MV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic [MV_W-1:0]   sense_mv,
  output logic [CODE_W-1:0] dch_code,
  output logic              ovld
);
  logic [NUM_THR-1:0] above;
  logic [CODE_W-1:0]  code_q, code_d;
  logic               ovl_q, ovl_d;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    assign above[g] = (32'(sense_mv) >= DCH_THR[g]);
  end

  always_comb begin
    code_d = code_q;
    ovl_d  = ovl_q;
    if (sample_stb) begin
      code_d = '0;
      for (int i = 0; i < NUM_THR; i++) begin
        if (above[i]) code_d = CODE_W'(i + 1);
      end
      ovl_d = above[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ovl_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      ovl_q  <= ovl_d;
    end
  end

  assign dch_code = code_q;
  assign ovld     = ovl_q;

  // R8: no strobe, no change
  p_hold_without_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable({code_q, ovl_q}));
  // R7: overload present exactly when the regime is above the lowest one
  p_ovld_agrees_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_q == (code_q != '0));
  // R6: code never exceeds the top regime
  p_code_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= CODE_W'(NUM_THR));
endmodule

// File: rtl/rate_flag_gen.sv
module rate_flag_gen
  import rfg_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 1000,
  parameter int unsigned MV_W       = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chg_start,
  input  logic            chg_pulse,
  input  logic [MV_W-1:0] sense_mv,
  input  logic            sample_stb,
  input  logic [7:0]      rd_addr,
  output logic [7:0]      rd_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              fast_chg;
  logic [CODE_W-1:0] dch_code;
  logic              ovld;
  status_t           status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  charge_rate_mon #(
    .WIN_CYCLES(WIN_CYCLES),
    .MIN_PULSES(2)
  ) i_chg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .chg_start(chg_start),
    .chg_pulse(chg_pulse),
    .fast_chg (fast_chg)
  );

  discharge_classifier #(
    .MV_W(MV_W)
  ) i_dch (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sample_stb(sample_stb),
    .sense_mv  (sense_mv),
    .dch_code  (dch_code),
    .ovld      (ovld)
  );

  always_comb begin
    status.fast_chg = fast_chg;
    status.dch_code = dch_code;
    status.rsv      = '0;
    status.ovld     = ovld;
  end

  assign rd_data = (rd_addr == STATUS_ADDR) ? status : 8'h00;
endmodule

// File: tb/test_rate_flag_gen.sv
module test_rate_flag_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 32;
  localparam int MVW        = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           chg_start, chg_pulse, sample_stb;
  logic [MVW-1:0] sense_mv;
  logic [7:0]     rd_addr;
  logic [7:0]     rd_data;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_flag_gen #(.WIN_CYCLES(WIN), .MV_W(MVW)) i_rate_flag_gen (
    .clk(clk), .rst_n(rst_n), .chg_start(chg_start), .chg_pulse(chg_pulse),
    .sense_mv(sense_mv), .sample_stb(sample_stb), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Reference model built from the requirements
  logic [1:0] m_sync;
  int         m_win, m_cnt;
  logic       m_cr, m_ovl;
  logic [2:0] m_code;

  function automatic logic [2:0] exp_code(input int mv);
    if (mv >= 253)      return 3'd4;
    else if (mv >= 150) return 3'd3;
    else if (mv >= 100) return 3'd2;
    else if (mv >= 50)  return 3'd1;
    else                return 3'd0;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    if (a != 8'h06) return 8'h00;
    return {m_cr, m_code, 3'b000, m_ovl};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 2'b00; m_win = 0; m_cnt = 0; m_cr = 0; m_code = 0; m_ovl = 0;
    end else begin
      if (m_sync[1]) begin
        if (chg_start) begin
          m_cr = 1; m_win = 0; m_cnt = chg_pulse ? 1 : 0;
        end else if (m_win == WIN-1) begin
          if (m_cnt + int'(chg_pulse) < 2) m_cr = 0;
          m_win = 0; m_cnt = 0;
        end else begin
          m_win++; m_cnt = m_cnt + int'(chg_pulse);
          if (m_cnt > 2) m_cnt = 2;
        end
        if (sample_stb) begin
          m_code = exp_code(int'(sense_mv));
          m_ovl  = (int'(sense_mv) >= 50);
        end
      end
      m_sync = {m_sync[0], 1'b1};
    end
  end

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Cycle-wise comparison at the falling edge, tagged by field
  task automatic cmp_now();
    logic [7:0] e;
    e = exp_byte(rd_addr);
    if (rd_addr != 8'h06) chk(rd_data == e, "R1", rd_data, e);
    else begin
      chk(rd_data[7]   == e[7],   "R4/R5 fast flag", rd_data, e);
      chk(rd_data[6:4] == e[6:4], "R6 code", rd_data, e);
      chk(rd_data[0]   == e[0],   "R7 overload", rd_data, e);
      chk(rd_data[3:1] == 3'b000, "R1 reserved", rd_data, e);
    end
  endtask

  task automatic step(input logic st, input logic pl, input logic sb, input int mv, input logic [7:0] a);
    chg_start = st; chg_pulse = pl; sample_stb = sb; sense_mv = MVW'(mv); rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    cmp_now();
  endtask

  initial begin
    int bnd [10] = '{49, 50, 99, 100, 149, 150, 252, 253, 0, 1023};
    void'($urandom(32'd1357));
    rst_n = 0; chg_start = 0; chg_pulse = 0; sample_stb = 0; sense_mv = '0; rd_addr = 8'h06;
    repeat (3) @(negedge clk);
    chk(rd_data == 8'h00, "R2 reset", rd_data, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk(rd_data == 8'h00, "R2 sync release", rd_data, 8'h00);
    step(0, 0, 0, 0, 8'h06);
    // R3: start sets flag at the next edge
    step(1, 0, 0, 0, 8'h06);
    chk(rd_data[7] == 1'b1, "R3 start", rd_data, 8'h80);
    // R6/R7 boundaries
    foreach (bnd[i]) step(0, 1, 1, bnd[i], 8'h06);
    // R8: values ignored without a strobe
    step(0, 0, 1, 200, 8'h06);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 10 + k * 300, 8'h06);
    chk(rd_data[6:0] == 7'b011_0001, "R8 hold", rd_data, 8'h31);
    // R1: other address reads zero
    step(0, 0, 0, 0, 8'h17);
    chk(rd_data == 8'h00, "R1 other addr", rd_data, 8'h00);
    // R5: sparse window clears the flag
    step(1, 0, 0, 0, 8'h06);
    for (int k = 0; k < WIN; k++) step(0, (k == 3), 0, 0, 8'h06);
    chk(rd_data[7] == 1'b0, "R5 sparse clear", rd_data, 8'h00);
    // R9: start on the last window cycle wins
    step(1, 0, 0, 0, 8'h06);
    while (m_win != WIN-1) step(0, 0, 0, 0, 8'h06);
    step(1, 0, 0, 0, 8'h06);
    chk(rd_data[7] == 1'b1, "R9 start wins", rd_data, 8'h80);
    // Random phases
    for (int ph = 0; ph < 60; ph++) begin
      int dens = $urandom_range(0, 3);
      for (int c = 0; c < 50; c++) begin
        logic [7:0] a = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'h06;
        step(($urandom_range(0, 199) == 0), ($urandom_range(0, 15) < dens),
             ($urandom_range(0, 3) == 0), $urandom_range(0, 400), a);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule